// File: doc/BRIEF.md
# Nonvolatile Memory Checksum Engine

This block computes and checks the integrity word of a small configuration image held in a nonvolatile memory. It reaches the memory through a simple word port that carries one request at a time: a read strobe or a write strobe, a word address and write data, answered by an acknowledge that may carry an error flag and read data. Adding the image words together modulo 2^16 must give the fixed signature 0xBABA. The image ends at a designated checksum word, which sits at index 0x3F by default.

A pulse on `start_i` begins one operation, and `mode_i` selects which one. In validate mode the engine reads every word from index 0 through the checksum word and reports whether the running total equals the signature. In update mode it reads the words below the checksum word and then writes into the checksum word the value that brings the total to the signature. If the memory answers any access with an error, the operation stops at once and reports a failure, and nothing is written back. `done_o` pulses for one cycle at the end of each operation. `valid_o` and `error_o` keep the outcome until the next start.

Top module: `nvm_sum_engine`

## Requirements
- R1: While reset is held, and in the first cycle after it, busy_o, done_o, valid_o, error_o, mem_rd_o and mem_wr_o are all low.
- R2: The total is a 16-bit sum that wraps modulo 2^16. Reads go to addresses in ascending order starting at 0, and a validate operation issues exactly CSUM_IDX+1 reads, the checksum word included.
- R3: mode_i=0 selects validate. When the 16-bit total equals 0xBABA, it ends with valid_o=1 and error_o=0. For any other total it ends with valid_o=0 and error_o=1. valid_o and error_o are never high together.
- R4: mode_i=1 selects update. It issues exactly CSUM_IDX reads (indices 0 to CSUM_IDX-1) and then one write to address CSUM_IDX carrying 0xBABA minus the total. If that write is acknowledged without error, the operation ends with valid_o=1 and error_o=0.
- R5: A read acknowledged with mem_err_i=1 ends the operation on that acknowledge with error_o=1 and valid_o=0. No further read is issued and no write takes place.
- R6: Only one of mem_rd_o and mem_wr_o is high at any time. A request keeps its strobe, address and write data unchanged until it is acknowledged.
- R7: done_o is high for exactly one cycle per operation. valid_o and error_o hold their value until the next accepted start, which clears both in the cycle that follows it.
- R8: A start_i pulse while busy_o is high is ignored: the running operation keeps its mode and its access sequence.
- R9: A write acknowledged with mem_err_i=1 ends an update with error_o=1 and valid_o=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Starts an operation while the engine is idle |
| mode_i | input | 1 | 0 = validate, 1 = update; sampled with start_i |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| valid_o | output | 1 | Last operation succeeded |
| error_o | output | 1 | Last operation failed (bad total or memory error) |
| mem_rd_o | output | 1 | Read request, held until acknowledged |
| mem_wr_o | output | 1 | Write request, held until acknowledged |
| mem_addr_o | output | ADDR_W | Word address of the current request |
| mem_wdata_o | output | DATA_W | Write data |
| mem_ack_i | input | 1 | Memory acknowledge |
| mem_err_i | input | 1 | Error response, qualified by mem_ack_i |
| mem_rdata_i | input | DATA_W | Read data, qualified by mem_ack_i |

## Verification
The engine is run on a striped image and on an image of all-ones words whose total wraps many times. Each image is first updated and then validated, which shows whether the written word really brings the total to the signature. A single flipped bit and an all-zero image must both fail validation, which separates a real comparison against 0xBABA from a comparison against zero. Read errors are injected at the first word, at the last word before the checksum word, at the checksum word itself and in the middle of the image, and the read and write counts are checked to confirm the abort point. A write error and a start pulse that arrives during a running operation complete the set.

// File: rtl/nvm_sum_pkg.sv
// Package: shared types for the checksum engine.
// Assumes: nothing beyond IEEE 1800-2017.
package nvm_sum_pkg;

    // Engine phase: idle, walking reads, or writing the checksum word.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_WRITE = 2'd2
    } sum_phase_t;

    // Operation selected with start.
    typedef enum logic {
        OP_VALIDATE = 1'b0,
        OP_UPDATE   = 1'b1
    } sum_op_t;

endpackage

// File: rtl/nvm_sum_accum.sv
// Module: running-total register.
// Does: clears on a new operation and adds each accepted read word modulo
//       2^DATA_W. It also offers the total including the word on the port and
//       the value that would bring the stored total to the signature.
// Assumes: add_i is asserted only for an error-free read acknowledge.
module nvm_sum_accum #(
    parameter int unsigned          DATA_W    = 16,
    parameter logic [DATA_W-1:0]    SIGNATURE = 16'hBABA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              add_i,
    input  logic [DATA_W-1:0] word_i,
    output logic [DATA_W-1:0] total_with_word_o,
    output logic [DATA_W-1:0] fill_o
);

    logic [DATA_W-1:0] total_q;

    // Holds the wrapped sum of all words accepted so far.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            total_q <= '0;
        end else if (clr_i) begin
            total_q <= '0;
        end else if (add_i) begin
            total_q <= total_q + word_i;
        end
    end

    // Sum including the word being acknowledged; used for the final compare.
    always_comb total_with_word_o = total_q + word_i;

    // Value that makes the total reach the signature.
    always_comb fill_o = SIGNATURE - total_q;

endmodule

// File: rtl/nvm_sum_walker.sv
// Module: address walker.
// Does: steps a word index from 0 and flags the last word to read for the
//       current operation. It drives the checksum address during write-back.
// Assumes: CSUM_IDX < 2**ADDR_W.
module nvm_sum_walker
    import nvm_sum_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned CSUM_IDX = 63
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              step_i,
    input  sum_op_t           op_i,
    input  logic              wr_phase_i,
    output logic              at_last_o,
    output logic [ADDR_W-1:0] addr_o
);

    localparam logic [ADDR_W-1:0] CSUM_A   = ADDR_W'(CSUM_IDX);
    localparam logic [ADDR_W-1:0] LAST_UPD = (CSUM_IDX == 0) ? '0 : ADDR_W'(CSUM_IDX - 1);

    logic [ADDR_W-1:0] idx_q;
    logic [ADDR_W-1:0] last_idx;

    // Index of the next word to read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (clr_i) begin
            idx_q <= '0;
        end else if (step_i) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    // Last read index depends on whether the checksum word is included.
    always_comb last_idx = (op_i == OP_UPDATE) ? LAST_UPD : CSUM_A;

    // Flags the final read of the walk.
    always_comb at_last_o = (idx_q == last_idx);

    // Address of the current request.
    always_comb addr_o = wr_phase_i ? CSUM_A : idx_q;

endmodule

// File: rtl/nvm_sum_ctrl.sv
// Module: operation sequencer.
// Does: accepts start while idle, walks reads one at a time, makes the
//       validate decision or moves to write-back, and records the outcome.
// Assumes: the memory acknowledges each held request exactly once.
module nvm_sum_ctrl
    import nvm_sum_pkg::*;
#(
    parameter int unsigned          DATA_W    = 16,
    parameter int unsigned          CSUM_IDX  = 63,
    parameter logic [DATA_W-1:0]    SIGNATURE = 16'hBABA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              mode_i,
    input  logic              ack_i,
    input  logic              err_i,
    input  logic              at_last_i,
    input  logic [DATA_W-1:0] total_i,
    output sum_phase_t        phase_o,
    output sum_op_t           op_o,
    output logic              clr_o,
    output logic              step_o,
    output logic              done_o,
    output logic              valid_o,
    output logic              error_o
);

    localparam bit NO_PRE_WORDS = (CSUM_IDX == 0);

    sum_phase_t phase_q;
    sum_op_t    op_q;
    logic       done_q, valid_q, error_q;
    logic       accept;

    // A start counts only while idle.
    always_comb accept = (phase_q == PH_IDLE) && start_i;

    // Phase, latched mode and outcome flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            op_q    <= OP_VALIDATE;
            done_q  <= 1'b0;
            valid_q <= 1'b0;
            error_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (accept) begin
                        op_q    <= sum_op_t'(mode_i);
                        valid_q <= 1'b0;
                        error_q <= 1'b0;
                        if (mode_i && NO_PRE_WORDS) phase_q <= PH_WRITE;
                        else                        phase_q <= PH_READ;
                    end
                end
                PH_READ: begin
                    if (ack_i) begin
                        if (err_i) begin
                            error_q <= 1'b1;
                            done_q  <= 1'b1;
                            phase_q <= PH_IDLE;
                        end else if (at_last_i) begin
                            if (op_q == OP_VALIDATE) begin
                                valid_q <= (total_i == SIGNATURE);
                                error_q <= (total_i != SIGNATURE);
                                done_q  <= 1'b1;
                                phase_q <= PH_IDLE;
                            end else begin
                                phase_q <= PH_WRITE;
                            end
                        end
                    end
                end
                PH_WRITE: begin
                    if (ack_i) begin
                        valid_q <= !err_i;
                        error_q <= err_i;
                        done_q  <= 1'b1;
                        phase_q <= PH_IDLE;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Datapath controls and registered outputs.
    always_comb begin
        clr_o   = accept;
        step_o  = (phase_q == PH_READ) && ack_i && !err_i;
        phase_o = phase_q;
        op_o    = op_q;
        done_o  = done_q;
        valid_o = valid_q;
        error_o = error_q;
    end

endmodule

// File: rtl/nvm_sum_engine.sv
// Module: checksum engine top.
// Does: validates or rewrites the integrity word of a nonvolatile image over
//       a one-request-at-a-time word port.
// Assumes: CSUM_IDX < 2**ADDR_W; the memory holds each request until it
//          acknowledges it, and mem_err_i is meaningful only with mem_ack_i.
module nvm_sum_engine
    import nvm_sum_pkg::*;
#(
    parameter int unsigned          ADDR_W    = 8,
    parameter int unsigned          DATA_W    = 16,
    parameter int unsigned          CSUM_IDX  = 63,
    parameter logic [DATA_W-1:0]    SIGNATURE = 16'hBABA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              mode_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              valid_o,
    output logic              error_o,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic              mem_ack_i,
    input  logic              mem_err_i,
    input  logic [DATA_W-1:0] mem_rdata_i
);

    sum_phase_t        phase;
    sum_op_t           op;
    logic              clr, step, at_last;
    logic [DATA_W-1:0] total_with_word, fill;

    nvm_sum_ctrl #(
        .DATA_W   (DATA_W),
        .CSUM_IDX (CSUM_IDX),
        .SIGNATURE(SIGNATURE)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .mode_i   (mode_i),
        .ack_i    (mem_ack_i),
        .err_i    (mem_err_i),
        .at_last_i(at_last),
        .total_i  (total_with_word),
        .phase_o  (phase),
        .op_o     (op),
        .clr_o    (clr),
        .step_o   (step),
        .done_o   (done_o),
        .valid_o  (valid_o),
        .error_o  (error_o)
    );

    nvm_sum_walker #(
        .ADDR_W  (ADDR_W),
        .CSUM_IDX(CSUM_IDX)
    ) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (clr),
        .step_i    (step),
        .op_i      (op),
        .wr_phase_i(phase == PH_WRITE),
        .at_last_o (at_last),
        .addr_o    (mem_addr_o)
    );

    nvm_sum_accum #(
        .DATA_W   (DATA_W),
        .SIGNATURE(SIGNATURE)
    ) u_acc (
        .clk              (clk),
        .rst_n            (rst_n),
        .clr_i            (clr),
        .add_i            (step),
        .word_i           (mem_rdata_i),
        .total_with_word_o(total_with_word),
        .fill_o           (fill)
    );

    // Request strobes and status follow the sequencer phase.
    always_comb begin
        busy_o      = (phase != PH_IDLE);
        mem_rd_o    = (phase == PH_READ);
        mem_wr_o    = (phase == PH_WRITE);
        mem_wdata_o = fill;
    end

endmodule

// File: rtl/nvm_sum_chk.sv
// Module: protocol and outcome checker, bound to the engine top.
// Does: watches the engine ports for request, abort and flag rules.
// Assumes: the same parameter values as the engine it is bound to.
module nvm_sum_chk #(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned CSUM_IDX = 63
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              valid_o,
    input logic              error_o,
    input logic              mem_rd_o,
    input logic              mem_wr_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              mem_ack_i,
    input logic              mem_err_i
);

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!busy_o && !done_o && !valid_o && !error_o && !mem_rd_o && !mem_wr_o));

    p_flags_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_o && error_o));

    p_write_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_o |-> (mem_addr_o == ADDR_W'(CSUM_IDX)));

    p_read_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o && mem_ack_i && mem_err_i) |=> (!mem_rd_o && !mem_wr_o && error_o && done_o));

    p_single_request_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_o && mem_wr_o));

    p_read_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o && !mem_ack_i) |=> (mem_rd_o && $stable(mem_addr_o)));

    p_write_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_o && !mem_ack_i) |=> (mem_wr_o && $stable(mem_addr_o)));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_flags_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(valid_o) && $stable(error_o)));

    p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !mem_ack_i) |=> busy_o);

endmodule

bind nvm_sum_engine nvm_sum_chk #(
    .ADDR_W  (ADDR_W),
    .CSUM_IDX(CSUM_IDX)
) u_sum_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .valid_o   (valid_o),
    .error_o   (error_o),
    .mem_rd_o  (mem_rd_o),
    .mem_wr_o  (mem_wr_o),
    .mem_addr_o(mem_addr_o),
    .mem_ack_i (mem_ack_i),
    .mem_err_i (mem_err_i)
);

// File: tb/tb_nvm_sum_engine.sv
// Bench: scoreboard for the checksum engine. A driver task computes the
// expected outcome from the bench memory image and queues it; a monitor pops
// it when done_o rises and compares. A memory model answers requests.
module tb_nvm_sum_engine;

    localparam int AW   = 8;
    localparam int DW   = 16;
    localparam int CSUM = 63;
    localparam logic [DW-1:0] SIG = 16'hBABA;

    typedef struct {
        bit          valid;
        bit          error;
        int          reads;
        int          writes;
        logic [15:0] word;
        string       tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic mode_i = 1'b0;
    logic busy_o, done_o, valid_o, error_o, mem_rd_o, mem_wr_o;
    logic [AW-1:0] mem_addr_o;
    logic [DW-1:0] mem_wdata_o;
    logic mem_ack_i = 1'b0;
    logic mem_err_i = 1'b0;
    logic [DW-1:0] mem_rdata_i = '0;

    logic [DW-1:0] mem [0:CSUM];
    int  rerr_addr = -1;
    bit  werr_en = 1'b0;
    int  rd_cnt = 0;
    int  wr_cnt = 0;
    bit  order_bad = 1'b0;
    bit  pending = 1'b0;
    int  checks = 0;
    int  errors = 0;
    exp_t q[$];

    always #5 clk = ~clk;

    nvm_sum_engine #(.ADDR_W(AW), .DATA_W(DW), .CSUM_IDX(CSUM), .SIGNATURE(SIG)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .busy_o(busy_o), .done_o(done_o), .valid_o(valid_o), .error_o(error_o),
        .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i), .mem_err_i(mem_err_i),
        .mem_rdata_i(mem_rdata_i)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Memory model: answers one held request per two cycles.
    always @(negedge clk) begin
        if (mem_ack_i) begin
            mem_ack_i = 1'b0;
            mem_err_i = 1'b0;
        end else if (mem_rd_o) begin
            if (int'(mem_addr_o) != rd_cnt) order_bad = 1'b1;
            rd_cnt++;
            mem_rdata_i = (int'(mem_addr_o) <= CSUM) ? mem[mem_addr_o] : '0;
            mem_err_i   = (rerr_addr == int'(mem_addr_o));
            mem_ack_i   = 1'b1;
        end else if (mem_wr_o) begin
            mem_err_i = werr_en;
            if (!werr_en && int'(mem_addr_o) <= CSUM) begin
                mem[mem_addr_o] = mem_wdata_o;
                wr_cnt++;
            end
            mem_ack_i = 1'b1;
        end
    end

    // Monitor: compares each finished operation with the queued expectation.
    initial begin
        forever begin
            @(negedge clk);
            if (done_o) begin
                exp_t e;
                bit v, er;
                if (q.size() == 0) begin
                    chk(1'b0, "R7 done without operation", 1, 0);
                end else begin
                    e = q.pop_front();
                    chk(valid_o == e.valid, {e.tag, " valid"}, valid_o, e.valid);
                    chk(error_o == e.error, {e.tag, " error"}, error_o, e.error);
                    chk(rd_cnt == e.reads, {e.tag, " reads"}, rd_cnt, e.reads);
                    chk(wr_cnt == e.writes, {e.tag, " writes"}, wr_cnt, e.writes);
                    chk(mem[CSUM] == e.word, {e.tag, " checksum word"}, mem[CSUM], e.word);
                    chk(!order_bad, "R2 ascending read order", order_bad, 0);
                end
                v = valid_o; er = error_o;
                @(negedge clk);
                chk(!done_o, "R7 done one cycle", done_o, 0);
                repeat (3) @(negedge clk);
                chk(valid_o == v && error_o == er, "R7 flags hold", {valid_o, error_o}, {v, er});
                pending = 1'b0;
            end
        end
    end

    function automatic logic [15:0] sum_to(input int last);
        logic [15:0] s = '0;
        for (int i = 0; i <= last; i++) s = s + mem[i];
        return s;
    endfunction

    // Driver: queue expectation, pulse start, optionally poke start while busy.
    task automatic run_op(input bit mode, input int rerr, input bit werr,
                          input bit poke, input string tag);
        exp_t e;
        int last = mode ? CSUM - 1 : CSUM;
        logic [15:0] s;
        e.tag = tag; e.valid = 0; e.error = 0; e.writes = 0; e.word = mem[CSUM];
        if (rerr >= 0 && rerr <= last) begin
            e.reads = rerr + 1; e.error = 1;
        end else begin
            s = sum_to(last);
            e.reads = last + 1;
            if (!mode) begin
                e.valid = (s == SIG); e.error = (s != SIG);
            end else if (werr) begin
                e.error = 1;
            end else begin
                e.valid = 1; e.writes = 1; e.word = SIG - s;
            end
        end
        q.push_back(e);
        rd_cnt = 0; wr_cnt = 0; order_bad = 0;
        rerr_addr = rerr; werr_en = werr; pending = 1'b1;
        @(negedge clk);
        start_i = 1'b1; mode_i = mode;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o && !valid_o && !error_o, "R7 start clears flags", {busy_o, valid_o, error_o}, 3'b100);
        if (poke) begin
            repeat (20) @(negedge clk);
            start_i = 1'b1; mode_i = ~mode;
            @(negedge clk);
            start_i = 1'b0; mode_i = mode;
        end
        while (pending) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy_o && !done_o && !valid_o && !error_o && !mem_rd_o && !mem_wr_o,
            "R1 reset state", {busy_o, done_o, valid_o, error_o, mem_rd_o, mem_wr_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !valid_o && !error_o, "R1 after release", {busy_o, valid_o, error_o}, 0);

        for (int i = 0; i <= CSUM; i++) mem[i] = 16'(i * 16'h0101 + 3);
        run_op(1'b1, -1, 1'b0, 1'b0, "R4 update striped");
        run_op(1'b0, -1, 1'b0, 1'b0, "R3 validate after update");
        mem[10] = mem[10] ^ 16'h0001;
        run_op(1'b0, -1, 1'b0, 1'b0, "R3 validate flipped bit");

        for (int i = 0; i < CSUM; i++) mem[i] = 16'hFFFF;
        run_op(1'b1, -1, 1'b0, 1'b0, "R2 update wrapping");
        run_op(1'b0, -1, 1'b0, 1'b0, "R2 validate wrapping");

        run_op(1'b0, 5, 1'b0, 1'b0, "R5 validate read error mid");
        run_op(1'b1, 0, 1'b0, 1'b0, "R5 update read error first");
        run_op(1'b1, CSUM - 1, 1'b0, 1'b0, "R5 update read error last");
        run_op(1'b0, CSUM, 1'b0, 1'b0, "R5 validate read error checksum word");
        run_op(1'b1, -1, 1'b1, 1'b0, "R9 update write error");
        run_op(1'b0, -1, 1'b0, 1'b1, "R8 start while busy");

        for (int i = 0; i <= CSUM; i++) mem[i] = '0;
        run_op(1'b0, -1, 1'b0, 1'b0, "R3 zero image fails");
        mem[CSUM] = SIG;
        run_op(1'b0, -1, 1'b0, 1'b0, "R3 signature only");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule